// File: doc/BRIEF.md
# Serial Byte Shifter with Address-Match Wake-Up

This block moves one byte at a time over a two-line synchronous serial bus, shifting the most significant bit first. A shift clock is picked from one of three sources: rising edges on an external clock pin, a pulse from a timer, or a divided-down copy of the system clock. After eight shift edges a transfer is complete, and the shift register then holds the byte that was received. The same register, loaded beforehand through the register port, supplies the outgoing bits.

A slave address register and a comparator drive a live match flag in the control register. The flag is forced low while the channel is disabled. By default an interrupt pulse follows every transfer. With the wake-up option on, the block stays quiet unless a byte arrives while the outside bus-release and command indications are both high and that byte equals the slave address. The option has no effect while the interrupt-timing select bit is set. Detecting the release and command conditions on the wire is left to surrounding logic.

Register map (2-bit address): 0 is control, 1 is slave address, 2 is the shift register (a write loads it), and 3 reads as zero. Control bits: bit 7 is enable, bit 6 is the read-only match flag, bit 5 is wake-up, bit 4 is interrupt-timing select, bits 3:2 are spare storage, and bits 1:0 select the clock source.

Top module: `sbw_wake_unit`

## Requirements
- R1: After reset, control reads 0x00, the shift register reads 0x00, `irq` is 0 and `sdo` is 0.
- R2: With effective wake-up off, `irq` is high for exactly one cycle, in the cycle the eighth shift of a transfer lands in the shift register, once per transfer.
- R3: With wake-up on (bit 5 = 1, bit 4 = 0), `irq` fires at the end of a transfer only if `bus_rel` and `bus_cmd` are both 1 at the eighth shift and the received byte equals the slave address.
- R4: While enabled, control bit 6 reads 1 exactly when the shift register equals the slave address.
- R5: While control bit 7 is 0, control bit 6 reads 0.
- R6: Each shift moves the register left and takes `sdi` into bit 0; `sdo` is bit 7 of the register, so the first bit received ends in the MSB.
- R7: Bits 1:0 select the clock source. With 00, a rising edge on `sclk_pin` causes one shift three system clocks after it is captured (two synchronizer flops, then edge detection). With 01, each `timer_tick` cycle causes one shift. With 10 or 11, a shift occurs every PRESCALE system cycles. Sources not selected have no effect.
- R8: When bit 4 is 1, bit 5 is ignored and an interrupt follows every transfer.
- R9: Writes to control bit 6 are ignored; all other control bits read back as written.
- R10: While disabled, no shifting occurs and the bit count is cleared. A write to address 2 loads the shift register and restarts the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| sclk_pin | input | 1 | External serial clock pin |
| timer_tick | input | 1 | Timer output pulse, system clock domain |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (register MSB) |
| bus_rel | input | 1 | Bus-release indication from outside |
| bus_cmd | input | 1 | Command indication from outside |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench builds the block with DATA_W = 8, PRESCALE = 4 and SYNC_STAGES = 2. With eight-bit bytes, the slave addresses and the bit patterns in the requirements can be used directly. The short prescaler lets several free-running transfers on the internal clock finish within a few hundred cycles. Two synchronizer stages give the three-cycle pin-to-shift latency that the reference model tracks on every clock.

// File: rtl/sbw_pkg.sv
`timescale 1ns/1ps
package sbw_pkg;
  localparam int CTRL_W    = 8;
  localparam int EN_BIT    = 7;
  localparam int MATCH_BIT = 6;
  localparam int WAKE_BIT  = 5;
  localparam int SIC_BIT   = 4;

  localparam logic [1:0] SRC_PIN   = 2'b00;
  localparam logic [1:0] SRC_TIMER = 2'b01;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_ADDR  = 2'd1;
  localparam logic [1:0] RA_SHIFT = 2'd2;
endpackage

// File: rtl/sbw_clk_sel.sv
`timescale 1ns/1ps
module sbw_clk_sel #(
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] src,
  input  logic       pin,
  input  logic       timer_tick,
  output logic       tick
);
  import sbw_pkg::*;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [SYNC_STAGES:0] sync_q, sync_d;
  logic [PW-1:0]        pre_q, pre_d;
  logic                 pin_rise, pre_last, sel;

  assign sync_d   = {sync_q[SYNC_STAGES-1:0], pin};
  assign pin_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign pre_last = (pre_q == PW'(PRESCALE - 1));

  always_comb begin
    if (!en || pre_last) pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
  end

  always_comb begin
    case (src)
      SRC_PIN:   sel = pin_rise;
      SRC_TIMER: sel = timer_tick;
      default:   sel = pre_last;
    endcase
    tick = en & sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      pre_q  <= '0;
    end else begin
      sync_q <= sync_d;
      pre_q  <= pre_d;
    end
  end
endmodule

// File: rtl/sbw_shifter.sv
`timescale 1ns/1ps
module sbw_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdi,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] data_d,
  output logic              done
);
  localparam int CW = $clog2(DATA_W);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last, step;

  assign last = (cnt_q == CW'(DATA_W - 1));
  assign step = en & tick & ~load;
  assign done = step & last;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (!en) cnt_d = '0;
    if (load) begin
      data_d = load_data;
      cnt_d  = '0;
    end else if (step) begin
      data_d = {data_q[DATA_W-2:0], sdi};
      cnt_d  = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sbw_regs.sv
`timescale 1ns/1ps
module sbw_regs #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_ctrl,
  input  logic                      wr_addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [sbw_pkg::CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0]         sva_q
);
  import sbw_pkg::*;

  logic [CTRL_W-1:0] ctrl_d;
  logic [DATA_W-1:0] sva_d;

  always_comb begin
    ctrl_d = ctrl_q;
    sva_d  = sva_q;
    if (wr_ctrl) begin
      ctrl_d            = wdata[CTRL_W-1:0];
      ctrl_d[MATCH_BIT] = 1'b0;
    end
    if (wr_addr) sva_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sva_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      sva_q  <= sva_d;
    end
  end
endmodule

// File: rtl/sbw_wake_unit.sv
`timescale 1ns/1ps
module sbw_wake_unit #(
  parameter int DATA_W      = 8,
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_pin,
  input  logic              timer_tick,
  input  logic              sdi,
  output logic              sdo,
  input  logic              bus_rel,
  input  logic              bus_cmd,
  output logic              irq
);
  import sbw_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_rd;
  logic [DATA_W-1:0] sva_q, shift_q, shift_d;
  logic              en, wake_eff, tick, done, match, irq_d, irq_q;
  logic              wr_ctrl, wr_addr, wr_shift;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign wr_ctrl  = reg_wr & (reg_addr == RA_CTRL);
  assign wr_addr  = reg_wr & (reg_addr == RA_ADDR);
  assign wr_shift = reg_wr & (reg_addr == RA_SHIFT);

  sbw_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_ctrl(wr_ctrl), .wr_addr(wr_addr),
    .wdata(reg_wdata), .ctrl_q(ctrl_q), .sva_q(sva_q));

  assign en       = ctrl_q[EN_BIT];
  assign wake_eff = ctrl_q[WAKE_BIT] & ~ctrl_q[SIC_BIT];

  sbw_clk_sel #(.SYNC_STAGES(SYNC_STAGES), .PRESCALE(PRESCALE)) u_clk (
    .clk(clk), .rst_n(rst_core_n), .en(en), .src(ctrl_q[1:0]),
    .pin(sclk_pin), .timer_tick(timer_tick), .tick(tick));

  sbw_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .en(en), .tick(tick), .load(wr_shift),
    .load_data(reg_wdata), .sdi(sdi), .data_q(shift_q), .data_d(shift_d),
    .done(done));

  assign match = en & (shift_q == sva_q);

  always_comb begin
    ctrl_rd            = ctrl_q;
    ctrl_rd[MATCH_BIT] = match;
    case (reg_addr)
      RA_CTRL:  reg_rdata = DATA_W'(ctrl_rd);
      RA_ADDR:  reg_rdata = sva_q;
      RA_SHIFT: reg_rdata = shift_q;
      default:  reg_rdata = '0;
    endcase
  end

  // end-of-transfer interrupt, gated by the address match when waking
  assign irq_d = done & (~wake_eff | (bus_rel & bus_cmd & (shift_d == sva_q)));

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq = irq_q;
  assign sdo = shift_q[DATA_W-1];
endmodule

// File: rtl/sbw_checker.sv
`timescale 1ns/1ps
module sbw_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              en,
  input logic              wake_eff,
  input logic              tick,
  input logic              bus_rel,
  input logic              bus_cmd,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] shift_q
);
  assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(en && tick));

  assert_wake_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(wake_eff)) |-> $past(bus_rel && bus_cmd));

  assert_flag_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && reg_addr == 2'd0) |-> !reg_rdata[6]);

  assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !(reg_wr && reg_addr == 2'd2)) |=>
      (shift_q[DATA_W-1:1] == $past(shift_q[DATA_W-2:0])));

  assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(reg_wr && reg_addr == 2'd2)) |=> $stable(shift_q));
endmodule

bind sbw_wake_unit sbw_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .irq(irq), .en(en), .wake_eff(wake_eff),
  .tick(tick), .bus_rel(bus_rel), .bus_cmd(bus_cmd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .shift_q(shift_q));

// File: tb/sbw_wake_unit_tb.sv
`timescale 1ns/1ps
module sbw_wake_unit_tb;
  localparam int PRESCALE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sclk_pin = 1'b0, timer_tick = 1'b0, sdi = 1'b0;
  logic       bus_rel = 1'b0, bus_cmd = 1'b0;
  logic       sdo, irq;

  int checks = 0, errors = 0, irq_seen = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  sbw_wake_unit #(.DATA_W(8), .PRESCALE(PRESCALE), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_pin(sclk_pin),
    .timer_tick(timer_tick), .sdi(sdi), .sdo(sdo), .bus_rel(bus_rel),
    .bus_cmd(bus_cmd), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising clock
  bit [7:0] m_ctrl, m_sva, m_sr;
  int       m_cnt, m_pre, m_rc;
  bit       m_irq, h0, h1, h2;

  function automatic bit [7:0] m_read(input bit [1:0] a);
    bit [7:0] c;
    c = m_ctrl;
    c[6] = m_ctrl[7] && (m_sr == m_sva);
    case (a)
      2'd0: return c;
      2'd1: return m_sva;
      2'd2: return m_sr;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    bit en, tk, wake;
    bit [7:0] nsr;
    if (!rst_n || m_rc < 2) begin
      if (!rst_n) m_rc = 0; else m_rc++;
      m_ctrl = 0; m_sva = 0; m_sr = 0; m_cnt = 0; m_pre = 0; m_irq = 0;
      h0 = 0; h1 = 0; h2 = 0;
    end else begin
      en   = m_ctrl[7];
      wake = m_ctrl[5] && !m_ctrl[4];
      case (m_ctrl[1:0])
        2'b00:   tk = h1 && !h2;
        2'b01:   tk = timer_tick;
        default: tk = (m_pre == PRESCALE - 1);
      endcase
      tk = tk && en;
      m_irq = 0;
      if (!en) m_cnt = 0;
      if (reg_wr && reg_addr == 2'd2) begin
        m_sr = reg_wdata; m_cnt = 0;
      end else if (tk) begin
        nsr = {m_sr[6:0], sdi};
        if (m_cnt == 7) begin
          m_cnt = 0;
          m_irq = !wake || (bus_rel && bus_cmd && nsr == m_sva);
        end else m_cnt++;
        m_sr = nsr;
      end
      if (!en || m_pre == PRESCALE - 1) m_pre = 0; else m_pre++;
      if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata & 8'hBF;
      if (reg_wr && reg_addr == 2'd1) m_sva = reg_wdata;
      h2 = h1; h1 = h0; h0 = sclk_pin;
    end
    #1;
    if (rst_n && !done_flag) begin
      check("R2 R3 irq", irq, m_irq);
      check("R6 sdo", sdo, m_sr[7]);
      check(reg_addr == 2'd0 ? "R4 R5 R9 rdata" : "R6 R10 rdata",
            reg_rdata, m_read(reg_addr));
    end
  end

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input bit [1:0] a, output bit [7:0] d);
    @(negedge clk); reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ext_bits(input bit [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sdi = b[i]; sclk_pin = 1;
      repeat (5) @(negedge clk);
      sclk_pin = 0;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic timer_byte(input bit [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sdi = b[i]; timer_tick = 1;
      @(negedge clk); timer_tick = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd2, v); check("R1 shift", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 sdo", sdo, 0);

    wr(2'd0, 8'h80);
    base = irq_seen; ext_bits(8'h3C, 8); repeat (4) @(negedge clk);
    check("R2 one irq per transfer", irq_seen - base, 1);
    rd(2'd2, v); check("R6 received byte", v, 8'h3C);
    rd(2'd0, v); check("R4 no match", v, 8'h80);
    wr(2'd1, 8'h3C);
    rd(2'd0, v); check("R4 match", v, 8'hC0);

    wr(2'd0, 8'h4C);
    rd(2'd0, v); check("R5 R9 disabled readback", v, 8'h0C);
    base = irq_seen; ext_bits(8'hFF, 8); repeat (4) @(negedge clk);
    rd(2'd2, v); check("R10 no shift when off", v, 8'h3C);
    check("R10 no irq when off", irq_seen - base, 0);

    wr(2'd2, 8'h81); wr(2'd0, 8'h80);
    @(negedge clk); check("R6 sdo is msb", sdo, 1);
    ext_bits(8'hE0, 3);
    wr(2'd2, 8'h00);
    base = irq_seen; ext_bits(8'hE7, 8); repeat (4) @(negedge clk);
    check("R10 count restarts on load", irq_seen - base, 1);
    rd(2'd2, v); check("R10 byte after restart", v, 8'hE7);

    wr(2'd1, 8'h5A); wr(2'd0, 8'hA0);
    bus_rel = 1; bus_cmd = 1;
    base = irq_seen; ext_bits(8'h5A, 8); repeat (4) @(negedge clk);
    check("R3 match wakes", irq_seen - base, 1);
    base = irq_seen; ext_bits(8'h11, 8); repeat (4) @(negedge clk);
    check("R3 mismatch quiet", irq_seen - base, 0);
    bus_cmd = 0;
    base = irq_seen; ext_bits(8'h5A, 8); repeat (4) @(negedge clk);
    check("R3 no command quiet", irq_seen - base, 0);
    bus_cmd = 1; bus_rel = 0;
    base = irq_seen; ext_bits(8'h5A, 8); repeat (4) @(negedge clk);
    check("R3 no release quiet", irq_seen - base, 0);

    wr(2'd0, 8'hB0); bus_cmd = 0;
    base = irq_seen; ext_bits(8'h11, 8); repeat (4) @(negedge clk);
    check("R8 timing bit overrides wake", irq_seen - base, 1);

    wr(2'd0, 8'h81);
    base = irq_seen; timer_byte(8'h96); repeat (2) @(negedge clk);
    check("R7 timer irq", irq_seen - base, 1);
    rd(2'd2, v); check("R7 timer byte", v, 8'h96);
    base = irq_seen; ext_bits(8'hFF, 8);
    check("R7 pin ignored in timer mode", irq_seen - base, 0);
    rd(2'd2, v); check("R7 pin ignored byte", v, 8'h96);

    sdi = 1;
    wr(2'd0, 8'h82);
    base = irq_seen; repeat (24 * PRESCALE + 2) @(negedge clk);
    check("R7 prescaled transfers", irq_seen - base, 3);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h83); sdi = 0;
    base = irq_seen; repeat (8 * PRESCALE + 2) @(negedge clk);
    check("R7 prescaled code 11", irq_seen - base, 1);
    rd(2'd2, v); check("R7 prescaled byte", v, 8'h00);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule